// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a keypad of mechanical contacts arranged as up to six rows by five columns. The rows are pulled up outside the block and read active low. The block drives the columns: a column driven low lets a closed contact in that column pull its row low. A slow single-cycle strobe, about once per millisecond, times both the debounce interval and the time each column is held during the scan.

In hardware mode the block runs a fixed cycle. It waits for any row to go low, debounces the press, walks the enabled columns one at a time and latches the row and column of the key it finds. It then sets a detect flag, which drives the interrupt when that is enabled. It waits for every row to return high and debounces that release before it starts again. Two size fields shrink the scanned matrix. With hardware scanning off, firmware drives the columns directly and reads the row lines itself.

Top module: `keypad_scanner`

## Requirements
- R1: After reset the detect flag, the interrupt, and the latched row and column are all 0.
- R2: The effective row count is `row_size` capped at 6, and the effective column count is `col_size` capped at 5. Rows and columns at or above the effective counts never produce a detection. In hardware mode, column outputs at or above the effective count are always driven high (1).
- R3: While waiting for a press, while debouncing, and while waiting for release, every enabled column is driven low (0) and the rest are driven high.
- R4: The debounce interval lasts max(`debounce_lim`,1) tick strobes. At the end of the interval the press is confirmed only if some enabled row still reads low. A contact that opens before then produces no detection and leaves the latched key unchanged.
- R5: The scan drives exactly one enabled column low at a time, in ascending order. Each column is held for max(`scan_lim`,1) ticks, and the rows are sampled at the end of that time. The first column that has a low row is reported. Within that column, the lowest-numbered low row is reported. `key_row` and `key_col` are binary indices counted from 0.
- R6: A detection sets `key_flag` whether or not `irq_en` is set. `irq` is high exactly when `key_flag` and `irq_en` are both high.
- R7: A one-cycle `flag_rd` strobe clears `key_flag` on the next clock edge, unless a detection happens in the same cycle.
- R8: After a detection, no further detection occurs until all enabled rows have read high for a full debounce interval. A key that is held down is reported only once.
- R9: With `hw_scan_en` low, `col_drv` equals `manual_cols`, the sequence stays idle, and key presses change neither the flag nor the latched key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle slow timing strobe (about 1 kHz) |
| hw_scan_en | input | 1 | 1 = hardware scanning, 0 = firmware drives columns |
| row_size | input | 3 | Number of rows scanned (capped at 6) |
| col_size | input | 3 | Number of columns scanned (capped at 5) |
| debounce_lim | input | 8 | Debounce interval in ticks |
| scan_lim | input | 8 | Per-column hold time in ticks |
| manual_cols | input | 5 | Column drive value used in bypass |
| irq_en | input | 1 | Interrupt enable |
| flag_rd | input | 1 | Read strobe that clears the detect flag |
| row_n | input | 6 | Row lines, active low |
| col_drv | output | 5 | Column drive, 0 = driven low |
| key_row | output | 3 | Latched row of the detected key |
| key_col | output | 3 | Latched column of the detected key |
| key_flag | output | 1 | Key detected flag |
| irq | output | 1 | Keypad interrupt |

## Verification
The assertions assume three things about the inputs. First, `row_n` is synchronous to `clk` and settles within the cycle in which `col_drv` changes. Second, `tick` is a single-cycle pulse. Third, the size fields and limits change only while hardware scanning is off, so an active scan never sees its column range shrink beneath it. The stimulus respects all three. A behavioural keypad in the bench derives `row_n` from the pressed keys and the current `col_drv`. Tick pulses fire every eighth clock. Sizes and limits are changed only after dropping `hw_scan_en`, and every input is driven on the falling edge.

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int NROW = 6,
  parameter int NCOL = 5,
  parameter int TW = 8,
  localparam int RSW = $clog2(NROW + 1),
  localparam int CSW = $clog2(NCOL + 1),
  localparam int RIW = (NROW > 1) ? $clog2(NROW) : 1,
  localparam int CIW = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            hw_scan_en,
  input  logic [RSW-1:0]  row_size,
  input  logic [CSW-1:0]  col_size,
  input  logic [TW-1:0]   debounce_lim,
  input  logic [TW-1:0]   scan_lim,
  input  logic [NCOL-1:0] manual_cols,
  input  logic            irq_en,
  input  logic            flag_rd,
  input  logic [NROW-1:0] row_n,
  output logic [NCOL-1:0] col_drv,
  output logic [RIW-1:0]  key_row,
  output logic [CIW-1:0]  key_col,
  output logic            key_flag,
  output logic            irq
);

  typedef enum logic [2:0] {S_IDLE, S_DBP, S_SCAN, S_WREL, S_DBR} st_t;

  st_t            state;
  logic [TW-1:0]  cnt;
  logic [CIW-1:0] scol;
  logic [RSW-1:0] nr_eff;
  logic [CSW-1:0] nc_eff;
  logic [NROW-1:0] row_en, row_hit;
  logic [NCOL-1:0] col_en;
  logic [RIW-1:0] low_row;
  logic [TW-1:0]  lim;
  logic           any_hit, wait_done, report;

  assign nr_eff = (row_size > RSW'(NROW)) ? RSW'(NROW) : row_size;
  assign nc_eff = (col_size > CSW'(NCOL)) ? CSW'(NCOL) : col_size;

  for (genvar g = 0; g < NROW; g++) begin : g_row
    assign row_en[g] = RSW'(g) < nr_eff;
  end
  for (genvar g = 0; g < NCOL; g++) begin : g_col
    assign col_en[g] = CSW'(g) < nc_eff;
    assign col_drv[g] = !hw_scan_en ? manual_cols[g]
                      : (state == S_SCAN) ? !(col_en[g] && CIW'(g) == scol)
                      : !col_en[g];
  end

  assign row_hit = ~row_n & row_en;
  assign any_hit = |row_hit;

  always_comb begin
    low_row = '0;
    for (int i = NROW - 1; i >= 0; i--)
      if (row_hit[i]) low_row = RIW'(i);
  end

  assign lim = (state == S_SCAN) ? scan_lim : debounce_lim;
  assign wait_done = tick && (({1'b0, cnt} + (TW+1)'(1)) >= {1'b0, lim});
  assign report = hw_scan_en && state == S_SCAN && wait_done && any_hit;
  assign irq = key_flag && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n || !hw_scan_en) begin
      state <= S_IDLE;
      cnt   <= '0;
      scol  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (any_hit) begin state <= S_DBP; cnt <= '0; end
        S_DBP: begin
          if (wait_done) begin
            cnt   <= '0;
            scol  <= '0;
            state <= any_hit ? S_SCAN : S_IDLE;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        S_SCAN: begin
          if (wait_done) begin
            cnt <= '0;
            if (any_hit) state <= S_WREL;
            else if ((CSW'(scol) + CSW'(1)) >= nc_eff) state <= S_IDLE;
            else scol <= scol + 1'b1;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        S_WREL: if (!any_hit) begin state <= S_DBR; cnt <= '0; end
        S_DBR: begin
          if (wait_done) begin
            cnt   <= '0;
            state <= any_hit ? S_WREL : S_IDLE;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_flag <= 1'b0;
      key_row  <= '0;
      key_col  <= '0;
    end else if (report) begin
      key_flag <= 1'b1;
      key_row  <= low_row;
      key_col  <= scol;
    end else if (flag_rd) begin
      key_flag <= 1'b0;
    end
  end

  p_scan_one_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_scan_en && state == S_SCAN) |-> $countones(~col_drv) == 1);

  p_bypass_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_scan_en |=> state == S_IDLE);

  p_flag_from_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_flag) |-> $past(state) == S_SCAN);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && state != S_SCAN) |=> !key_flag);

  p_release_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WREL) |=> (state == S_WREL || state == S_DBR || state == S_IDLE));

  p_idle_to_debounce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_scan_en && state == S_IDLE) |=> (state == S_IDLE || state == S_DBP));

endmodule

// File: tb/keypad_scanner_tb_top.sv
`timescale 1ns/1ps
module keypad_scanner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic hw_scan_en = 1'b1;
  logic [2:0] row_size = 3'd6;
  logic [2:0] col_size = 3'd5;
  logic [7:0] debounce_lim = 8'd3;
  logic [7:0] scan_lim = 8'd2;
  logic [4:0] manual_cols = 5'b11111;
  logic irq_en = 1'b1;
  logic flag_rd = 1'b0;
  logic [5:0] row_n;
  logic [4:0] col_drv;
  logic [2:0] key_row, key_col;
  logic key_flag, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit pressed [6][5];

  always #2.5 clk = ~clk;

  keypad_scanner dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hw_scan_en(hw_scan_en),
    .row_size(row_size), .col_size(col_size), .debounce_lim(debounce_lim),
    .scan_lim(scan_lim), .manual_cols(manual_cols), .irq_en(irq_en),
    .flag_rd(flag_rd), .row_n(row_n), .col_drv(col_drv), .key_row(key_row),
    .key_col(key_col), .key_flag(key_flag), .irq(irq));

  always_comb begin
    for (int r = 0; r < 6; r++) begin
      row_n[r] = 1'b1;
      for (int c = 0; c < 5; c++)
        if (pressed[r][c] && !col_drv[c]) row_n[r] = 1'b0;
    end
  end

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 8 == 0);
  end

  // behavioural reference: phases 0 idle, 1 press debounce, 2 scan, 3 held, 4 release debounce
  int m_ph, m_cnt, m_col, m_krow, m_kcol;
  bit m_flag;

  function automatic int nr_m();
    return (row_size > 6) ? 6 : int'(row_size);
  endfunction
  function automatic int nc_m();
    return (col_size > 5) ? 5 : int'(col_size);
  endfunction
  function automatic int m_low(int ph, int col);
    for (int r = 0; r < nr_m(); r++)
      for (int c = 0; c < nc_m(); c++)
        if (pressed[r][c] && (ph != 2 || c == col)) return r;
    return -1;
  endfunction
  function automatic logic [4:0] m_cols();
    logic [4:0] v;
    if (!hw_scan_en) return manual_cols;
    for (int c = 0; c < 5; c++) v[c] = !(c < nc_m() && (m_ph != 2 || c == m_col));
    return v;
  endfunction

  always @(posedge clk) begin
    int lr, lim;
    bit dn, rep;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_col = 0; m_krow = 0; m_kcol = 0; m_flag = 0;
    end else begin
      lr = m_low(m_ph, m_col);
      lim = (m_ph == 2) ? int'(scan_lim) : int'(debounce_lim);
      dn = tick && (m_cnt + 1 >= lim);
      rep = 0;
      if (!hw_scan_en) begin
        m_ph = 0; m_cnt = 0; m_col = 0;
      end else begin
        case (m_ph)
          0: if (lr >= 0) begin m_ph = 1; m_cnt = 0; end
          1: if (dn) begin m_cnt = 0; m_col = 0; m_ph = (lr >= 0) ? 2 : 0; end
             else if (tick) m_cnt++;
          2: if (dn) begin
               m_cnt = 0;
               if (lr >= 0) begin rep = 1; m_krow = lr; m_kcol = m_col; m_ph = 3; end
               else if (m_col + 1 >= nc_m()) m_ph = 0;
               else m_col++;
             end else if (tick) m_cnt++;
          3: if (lr < 0) begin m_ph = 4; m_cnt = 0; end
          4: if (dn) begin m_cnt = 0; m_ph = (lr >= 0) ? 3 : 0; end
             else if (tick) m_cnt++;
          default: m_ph = 0;
        endcase
      end
      if (rep) m_flag = 1;
      else if (flag_rd) m_flag = 0;
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R3 col_drv vs model", col_drv, m_cols());
      chk("R6 key_flag vs model", key_flag, m_flag);
      chk("R6 irq vs model", irq, m_flag && irq_en);
      chk("R5 key_row vs model", key_row, m_krow);
      chk("R5 key_col vs model", key_col, m_kcol);
    end
  end

  task automatic wt(int n);
    repeat (n * 8) @(negedge clk);
  endtask
  task automatic rd();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask
  task automatic release_all();
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 5; c++) pressed[r][c] = 0;
  endtask
  task automatic cfg(int rs, int cs, int db);
    @(negedge clk); hw_scan_en = 1'b0;
    @(negedge clk);
    row_size = 3'(rs); col_size = 3'(cs); debounce_lim = 8'(db);
    @(negedge clk); hw_scan_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    release_all();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", key_flag, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 row after reset", key_row, 0);
    chk("R1 col after reset", key_col, 0);
    chk("R3 idle columns", col_drv, 5'b00000);

    pressed[1][2] = 1; wt(20);
    chk("R5 row", key_row, 1); chk("R5 col", key_col, 2);
    chk("R6 flag", key_flag, 1); chk("R6 irq", irq, 1);
    chk("R3 held columns", col_drv, 5'b00000);
    rd();
    chk("R7 flag cleared", key_flag, 0); chk("R7 irq cleared", irq, 0);
    wt(10);
    chk("R8 held key not re-reported", key_flag, 0);
    release_all(); wt(10);
    pressed[5][4] = 1; wt(20);
    chk("R5 row corner", key_row, 5); chk("R5 col corner", key_col, 4);
    rd(); release_all(); wt(10);

    cfg(6, 5, 6);
    pressed[0][0] = 1; wt(2); release_all(); wt(15);
    chk("R4 bounce no flag", key_flag, 0);
    chk("R4 bounce key kept", key_row, 5);

    cfg(6, 5, 3);
    pressed[3][1] = 1; pressed[2][3] = 1; wt(20);
    chk("R5 lowest column first row", key_row, 3); chk("R5 lowest column", key_col, 1);
    rd(); release_all(); wt(10);
    pressed[4][1] = 1; pressed[2][1] = 1; wt(20);
    chk("R5 lowest row", key_row, 2); chk("R5 same column", key_col, 1);
    rd(); release_all(); wt(10);

    cfg(3, 3, 3);
    chk("R2 disabled columns high", col_drv, 5'b11000);
    pressed[4][1] = 1; wt(20);
    chk("R2 row outside size", key_flag, 0);
    release_all(); wt(5);
    pressed[1][4] = 1; wt(20);
    chk("R2 col outside size", key_flag, 0);
    release_all(); wt(5);
    pressed[2][2] = 1; wt(20);
    chk("R2 inside size flag", key_flag, 1);
    chk("R2 inside size row", key_row, 2); chk("R2 inside size col", key_col, 2);
    rd(); release_all(); wt(10);

    cfg(7, 7, 3);
    chk("R2 clamped columns", col_drv, 5'b00000);
    pressed[5][4] = 1; wt(20);
    chk("R2 clamped row", key_row, 5); chk("R2 clamped col", key_col, 4);
    rd(); release_all(); wt(10);

    @(negedge clk); irq_en = 1'b0;
    pressed[0][3] = 1; wt(20);
    chk("R6 flag without irq_en", key_flag, 1); chk("R6 irq masked", irq, 0);
    @(negedge clk); irq_en = 1'b1; @(negedge clk);
    chk("R6 irq follows enable", irq, 1);
    rd(); release_all(); wt(10);

    @(negedge clk); hw_scan_en = 1'b0; manual_cols = 5'b10101;
    @(negedge clk);
    chk("R9 manual drive", col_drv, 5'b10101);
    pressed[0][1] = 1; wt(20);
    chk("R9 rows follow manual drive", row_n[0], 0);
    chk("R9 no flag in bypass", key_flag, 0);
    chk("R9 key kept in bypass", key_col, 3);
    release_all(); @(negedge clk); hw_scan_en = 1'b1; wt(5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule